// File: doc/BRIEF.md
# Integer ALU Execute Decoder

This block is the combinational execute stage of a 32-bit load/store RISC integer pipeline. On every cycle it takes the fetched instruction word and the two source register values that the register file has already read. It returns a computed result, the index of the register that should receive it, a write-enable and an unimplemented flag. The decoder handles the immediate-form arithmetic and logic instructions, the register-form arithmetic and logic instructions, signed minimum and maximum, leading-zero and leading-one counting, and the two conditional moves. No destination write is ever issued to register zero.

The instruction word is split into a major opcode in bits 31:26, a first source index in bits 25:21, a second-source or immediate destination index in bits 20:16, a register destination in bits 15:11 and a function code in bits 5:0. The low half-word, bits 15:0, is the immediate. Whenever the decoder does not recognise an encoding, it raises the unimplemented flag and writes nothing. The pipeline can then pass that instruction on to a slower handler.

Top module: `risc_alu_exec`

## Requirements
- R1: Major opcodes 8 and 9 both return srcA plus the sign-extended immediate, wrapping modulo 2^32 with no trap. The destination index is instruction bits 20:16.
- R2: Major opcodes 12, 13 and 14 return srcA AND, OR and XOR (in that order) with the zero-extended immediate.
- R3: Major opcode 10 returns 1 when srcA is less than the sign-extended immediate as signed values, and 0 otherwise. Major opcode 11 makes the same comparison unsigned, against the sign-extended immediate read as unsigned.
- R4: Major opcode 15 returns the immediate in bits 31:16 with bits 15:0 cleared.
- R5: With major opcode 0, function codes 32 and 33 return srcA+srcB, and 34 and 35 return srcA-srcB, both wrapping. The destination index is instruction bits 15:11.
- R6: With major opcode 0, function codes 36, 37, 38 and 39 return AND, OR, XOR and NOR of srcA and srcB.
- R7: With major opcode 0, function 42 returns 1 or 0 for srcA less than srcB compared as signed values, and function 43 does the same compared as unsigned values.
- R8: With major opcode 0, function 44 returns the signed maximum of srcA and srcB, and function 45 returns the signed minimum.
- R9: With major opcode 0, function 22 returns the number of leading zero bits of srcA, and function 23 returns the number of leading one bits. An all-zero word (for 22) or an all-one word (for 23) gives 32.
- R10: With major opcode 0, function 10 returns srcA and enables the write only when srcB is zero. Function 11 returns srcA and enables the write only when srcB is nonzero. When the condition fails, the write-enable is low.
- R11: When the selected destination index is 0, the write-enable is low for every instruction.
- R12: Any other major opcode, or any other function code under major opcode 0, sets the unimplemented flag and drives the write-enable low, the result to 0 and the destination index to 0. Every recognised encoding clears the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr | input | 32 | Instruction word under execution |
| srcA | input | 32 | Value of the register named by bits 25:21 |
| srcB | input | 32 | Value of the register named by bits 20:16 |
| result | output | 32 | Computed value to write back |
| destIdx | output | 5 | Register index that receives the result |
| wrEn | output | 1 | Write-back enable |
| unimpl | output | 1 | Encoding not handled by this stage |

## Verification
The embedded checks hold on every evaluation:
- A write-enable never names register 0.
- An illegal encoding never carries a destination.
- Comparison results are only 0 or 1.
- The maximum and minimum results are one of the operands and bound both of them.
- A leading-bit count never exceeds the word width and is zero whenever the top bit is set.

Only the bench sweep can show that each opcode and function code selects the right arithmetic. The sweep also covers the sign and zero extension of the immediate, the failing branch of each conditional move, and the boundary operand values: all zeros, all ones, and the most negative and most positive words.

// File: rtl/alu_exec_pkg.sv
package alu_exec_pkg;

  typedef enum logic [3:0] {
    ALU_ADD,
    ALU_SUB,
    ALU_AND,
    ALU_OR,
    ALU_XOR,
    ALU_NOR,
    ALU_SLT,
    ALU_SLTU,
    ALU_MAX,
    ALU_MIN,
    ALU_LUI,
    ALU_CLZ,
    ALU_CLO,
    ALU_PASS
  } aluOpE;

  typedef struct packed {
    aluOpE op;
    logic  useImm;
    logic  zeroExtImm;
    logic  condMove;
    logic  moveOnZero;
    logic  illegal;
  } ctrlStrobesT;

  localparam int OPC_W   = 6;
  localparam int FUNC_W  = 6;
  localparam int REGIX_W = 5;
  localparam int IMM_W   = 16;

endpackage

// File: rtl/alu_lead_count.sv
module alu_lead_count #(
  parameter int DATA_W = 32,
  localparam int CNT_W = $clog2(DATA_W + 1)
) (
  input  logic [DATA_W-1:0] word,
  output logic [CNT_W-1:0]  count
);

  always_comb begin
    count = CNT_W'(DATA_W);
    for (int i = 0; i < DATA_W; i++) begin
      if (word[i]) count = CNT_W'(DATA_W - 1 - i);
    end
    assert_count_bound_R9: assert (count <= CNT_W'(DATA_W))
      else $error("leading count above width");
    assert_msb_zero_count_R9: assert (!word[DATA_W-1] || count == '0)
      else $error("leading count nonzero with top bit set");
  end

endmodule

// File: rtl/alu_control.sv
module alu_control
  import alu_exec_pkg::*;
(
  input  logic [OPC_W-1:0]   opcode,
  input  logic [FUNC_W-1:0]  funct,
  input  logic [REGIX_W-1:0] rtField,
  input  logic [REGIX_W-1:0] rdField,
  output ctrlStrobesT        strobes,
  output logic [REGIX_W-1:0] destIdx
);

  localparam logic [OPC_W-1:0] OPC_REG = '0;

  always_comb begin
    strobes            = '0;
    strobes.op         = ALU_PASS;
    if (opcode == OPC_REG) begin
      unique case (funct)
        6'd32, 6'd33: strobes.op = ALU_ADD;
        6'd34, 6'd35: strobes.op = ALU_SUB;
        6'd36:        strobes.op = ALU_AND;
        6'd37:        strobes.op = ALU_OR;
        6'd38:        strobes.op = ALU_XOR;
        6'd39:        strobes.op = ALU_NOR;
        6'd42:        strobes.op = ALU_SLT;
        6'd43:        strobes.op = ALU_SLTU;
        6'd44:        strobes.op = ALU_MAX;
        6'd45:        strobes.op = ALU_MIN;
        6'd22:        strobes.op = ALU_CLZ;
        6'd23:        strobes.op = ALU_CLO;
        6'd10: begin
          strobes.op         = ALU_PASS;
          strobes.condMove   = 1'b1;
          strobes.moveOnZero = 1'b1;
        end
        6'd11: begin
          strobes.op         = ALU_PASS;
          strobes.condMove   = 1'b1;
          strobes.moveOnZero = 1'b0;
        end
        default: strobes.illegal = 1'b1;
      endcase
    end else begin
      strobes.useImm = 1'b1;
      unique case (opcode)
        6'd8, 6'd9: strobes.op = ALU_ADD;
        6'd12: begin strobes.op = ALU_AND; strobes.zeroExtImm = 1'b1; end
        6'd13: begin strobes.op = ALU_OR;  strobes.zeroExtImm = 1'b1; end
        6'd14: begin strobes.op = ALU_XOR; strobes.zeroExtImm = 1'b1; end
        6'd10: strobes.op = ALU_SLT;
        6'd11: strobes.op = ALU_SLTU;
        6'd15: strobes.op = ALU_LUI;
        default: strobes.illegal = 1'b1;
      endcase
    end

    if (strobes.illegal)           destIdx = '0;
    else if (opcode == OPC_REG)    destIdx = rdField;
    else                           destIdx = rtField;

    assert_illegal_no_dest_R12: assert (!strobes.illegal || destIdx == '0)
      else $error("illegal encoding carries a destination");
    assert_imm_form_no_cmove_R10: assert (opcode == OPC_REG || !strobes.condMove)
      else $error("conditional move decoded outside register form");
  end

endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_exec_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int CNT_W = $clog2(DATA_W + 1)
) (
  input  ctrlStrobesT        strobes,
  input  logic [IMM_W-1:0]   imm,
  input  logic [REGIX_W-1:0] destIdx,
  input  logic [DATA_W-1:0]  srcA,
  input  logic [DATA_W-1:0]  srcB,
  output logic [DATA_W-1:0]  result,
  output logic               wrEn
);

  logic [DATA_W-1:0] lzIn;
  logic [CNT_W-1:0]  lzCount;
  logic [DATA_W-1:0] immExt;
  logic [DATA_W-1:0] opB;
  logic [DATA_W-1:0] rawRes;
  logic              condOk;
  logic              aLtBSigned;
  logic              aLtBUnsigned;

  assign lzIn = (strobes.op == ALU_CLO) ? ~srcA : srcA;

  alu_lead_count #(.DATA_W(DATA_W)) uLeadCount (
    .word  (lzIn),
    .count (lzCount)
  );

  always_comb begin
    if (strobes.zeroExtImm) immExt = {{(DATA_W-IMM_W){1'b0}}, imm};
    else                    immExt = {{(DATA_W-IMM_W){imm[IMM_W-1]}}, imm};
    opB          = strobes.useImm ? immExt : srcB;
    aLtBSigned   = $signed(srcA) < $signed(opB);
    aLtBUnsigned = srcA < opB;

    unique case (strobes.op)
      ALU_ADD:  rawRes = srcA + opB;
      ALU_SUB:  rawRes = srcA - opB;
      ALU_AND:  rawRes = srcA & opB;
      ALU_OR:   rawRes = srcA | opB;
      ALU_XOR:  rawRes = srcA ^ opB;
      ALU_NOR:  rawRes = ~(srcA | opB);
      ALU_SLT:  rawRes = DATA_W'(aLtBSigned);
      ALU_SLTU: rawRes = DATA_W'(aLtBUnsigned);
      ALU_MAX:  rawRes = aLtBSigned ? opB : srcA;
      ALU_MIN:  rawRes = aLtBSigned ? srcA : opB;
      ALU_LUI:  rawRes = {imm, {(DATA_W-IMM_W){1'b0}}};
      ALU_CLZ, ALU_CLO: rawRes = DATA_W'(lzCount);
      default:  rawRes = srcA;
    endcase

    condOk = !strobes.condMove || ((srcB == '0) == strobes.moveOnZero);
    wrEn   = !strobes.illegal && (destIdx != '0) && condOk;
    result = strobes.illegal ? '0 : rawRes;

    assert_no_zero_write_R11: assert (!wrEn || destIdx != '0)
      else $error("write enabled toward register zero");
    assert_illegal_quiet_R12: assert (!strobes.illegal || (!wrEn && result == '0))
      else $error("illegal encoding produced a write");
    assert_cmp_is_bit_R7: assert (!(strobes.op inside {ALU_SLT, ALU_SLTU})
                                  || strobes.illegal || result[DATA_W-1:1] == '0)
      else $error("comparison result wider than one bit");
    assert_cmove_cond_R10: assert (!(strobes.condMove && wrEn)
                                   || ((srcB == '0) == strobes.moveOnZero))
      else $error("conditional move wrote with failed condition");
    if (!strobes.illegal && strobes.op == ALU_MAX) begin
      assert_max_bound_R8: assert ($signed(result) >= $signed(srcA)
                                   && $signed(result) >= $signed(opB)
                                   && (result == srcA || result == opB))
        else $error("max result does not bound operands");
    end
    if (!strobes.illegal && strobes.op == ALU_MIN) begin
      assert_min_bound_R8: assert ($signed(result) <= $signed(srcA)
                                   && $signed(result) <= $signed(opB)
                                   && (result == srcA || result == opB))
        else $error("min result does not bound operands");
    end
  end

endmodule

// File: rtl/risc_alu_exec.sv
module risc_alu_exec
  import alu_exec_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [31:0]        instr,
  input  logic [DATA_W-1:0]  srcA,
  input  logic [DATA_W-1:0]  srcB,
  output logic [DATA_W-1:0]  result,
  output logic [REGIX_W-1:0] destIdx,
  output logic               wrEn,
  output logic               unimpl
);

  ctrlStrobesT strobes;
  logic        unusedRsField;

  assign unusedRsField = ^instr[25:21];

  alu_control uControl (
    .opcode  (instr[31:26]),
    .funct   (instr[5:0]),
    .rtField (instr[20:16]),
    .rdField (instr[15:11]),
    .strobes (strobes),
    .destIdx (destIdx)
  );

  alu_datapath #(.DATA_W(DATA_W)) uDatapath (
    .strobes (strobes),
    .imm     (instr[15:0]),
    .destIdx (destIdx),
    .srcA    (srcA),
    .srcB    (srcB),
    .result  (result),
    .wrEn    (wrEn)
  );

  assign unimpl = strobes.illegal;

endmodule

// File: tb/sim_risc_alu_exec.sv
`timescale 1ns/1ps
module sim_risc_alu_exec;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] instr = '0;
  logic [31:0] srcA = '0;
  logic [31:0] srcB = '0;
  logic [31:0] result;
  logic [4:0]  destIdx;
  logic        wrEn;
  logic        unimpl;

  int vecCount = 0;
  int missCount = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  risc_alu_exec u0 (
    .instr(instr), .srcA(srcA), .srcB(srcB),
    .result(result), .destIdx(destIdx), .wrEn(wrEn), .unimpl(unimpl)
  );

  logic [31:0] patA [8] = '{32'h0, 32'hFFFFFFFF, 32'h80000000, 32'h7FFFFFFF,
                            32'h12345678, 32'h0000FFFF, 32'h00010000, 32'h0F0F0000};
  logic [31:0] patB [8] = '{32'h0, 32'h1, 32'h7FFFFFFF, 32'h80000000,
                            32'h0, 32'hFFFF0000, 32'h1, 32'hF0F0F0F0};
  logic [15:0] patI [8] = '{16'h0, 16'hFFFF, 16'h8000, 16'h7FFF,
                            16'h1234, 16'h00FF, 16'hFFFE, 16'h5A5A};

  function automatic logic [31:0] leadZeros(input logic [31:0] w);
    int n = 0;
    for (int i = 31; i >= 0; i--) begin
      if (w[i]) break;
      n++;
    end
    return 32'(n);
  endfunction

  function automatic string reqOf(input logic [31:0] ins, input bit un, input bit dz);
    logic [5:0] opc = ins[31:26];
    logic [5:0] fn  = ins[5:0];
    if (un) return "R12";
    if (dz) return "R11";
    if (opc != 0) begin
      case (opc)
        6'd8, 6'd9: return "R1";
        6'd12, 6'd13, 6'd14: return "R2";
        6'd15: return "R4";
        default: return "R3";
      endcase
    end
    case (fn)
      6'd32, 6'd33, 6'd34, 6'd35: return "R5";
      6'd42, 6'd43: return "R7";
      6'd44, 6'd45: return "R8";
      6'd22, 6'd23: return "R9";
      6'd10, 6'd11: return "R10";
      default: return "R6";
    endcase
  endfunction

  task automatic applyVec(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b);
    logic [5:0]  opc = ins[31:26];
    logic [5:0]  fn  = ins[5:0];
    logic [15:0] im  = ins[15:0];
    logic [31:0] sx  = {{16{im[15]}}, im};
    logic [31:0] zx  = {16'h0, im};
    logic [31:0] eRes = '0;
    logic [4:0]  eDest;
    bit          eUn = 1'b0;
    bit          cond = 1'b1;
    bit          eWe;
    @(posedge clk);
    instr = ins; srcA = a; srcB = b;
    if (opc == 0) begin
      eDest = ins[15:11];
      case (fn)
        6'd32, 6'd33: eRes = a + b;
        6'd34, 6'd35: eRes = a - b;
        6'd36: eRes = a & b;
        6'd37: eRes = a | b;
        6'd38: eRes = a ^ b;
        6'd39: eRes = ~(a | b);
        6'd42: eRes = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
        6'd43: eRes = (a < b) ? 32'd1 : 32'd0;
        6'd44: eRes = ($signed(a) > $signed(b)) ? a : b;
        6'd45: eRes = ($signed(a) < $signed(b)) ? a : b;
        6'd22: eRes = leadZeros(a);
        6'd23: eRes = leadZeros(~a);
        6'd10: begin eRes = a; cond = (b == 0); end
        6'd11: begin eRes = a; cond = (b != 0); end
        default: eUn = 1'b1;
      endcase
    end else begin
      eDest = ins[20:16];
      case (opc)
        6'd8, 6'd9: eRes = a + sx;
        6'd12: eRes = a & zx;
        6'd13: eRes = a | zx;
        6'd14: eRes = a ^ zx;
        6'd10: eRes = ($signed(a) < $signed(sx)) ? 32'd1 : 32'd0;
        6'd11: eRes = (a < sx) ? 32'd1 : 32'd0;
        6'd15: eRes = {im, 16'h0};
        default: eUn = 1'b1;
      endcase
    end
    if (eUn) begin eRes = '0; eDest = '0; end
    eWe = !eUn && (eDest != 0) && cond;
    #1;
    vecCount++;
    if (result !== eRes || destIdx !== eDest || wrEn !== eWe || unimpl !== eUn) begin
      missCount++;
      $display("FAIL %s instr=%h a=%h b=%h got res=%h dst=%0d we=%b un=%b exp res=%h dst=%0d we=%b un=%b",
               reqOf(ins, eUn, eDest == 0), ins, a, b, result, destIdx, wrEn, unimpl,
               eRes, eDest, eWe, eUn);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    // Reset state: all-zero instruction is an unsupported function (R12)
    applyVec(32'h0, 32'h0, 32'h0);
    // R1 wrap and R9 boundary values
    applyVec({6'd9, 5'd1, 5'd2, 16'h0001}, 32'hFFFFFFFF, 32'h0);
    applyVec({6'd0, 5'd1, 5'd2, 5'd3, 5'd0, 6'd22}, 32'h00000001, 32'h0);
    applyVec({6'd0, 5'd1, 5'd2, 5'd3, 5'd0, 6'd23}, 32'hFFFFFFFF, 32'h0);
    for (int opc = 0; opc < 64; opc++) begin
      if (opc == 0) begin
        for (int fn = 0; fn < 64; fn++)
          for (int p = 0; p < 8; p++)
            for (int d = 0; d < 2; d++)
              applyVec({6'd0, 5'd3, 5'd4, (d != 0) ? 5'd9 : 5'd0, 5'd0, 6'(fn)},
                       patA[p], patB[p]);
      end else begin
        for (int p = 0; p < 8; p++)
          for (int d = 0; d < 2; d++)
            applyVec({6'(opc), 5'd3, (d != 0) ? 5'd5 : 5'd0, patI[p]},
                     patA[p], patB[p]);
      end
    end
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      missCount++;
      $display("FAIL watchdog expired got running expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
      $finish;
    end
  end

endmodule